// File: doc/BRIEF.md
# Mode-Switchable Serial Receive Buffer

This block stores received bytes for a PC-style serial port between the byte source and the software read path. The byte source is either the line receiver or an internal loopback path. The block has two sizes, selected by an enable bit that software writes into the port's FIFO control register:

- **Legacy mode** holds exactly one byte.
- **FIFO mode** holds up to `DEPTH` bytes, 16 by default.

The store is a circular array with separate read and write indices. Both indices wrap at the depth of the current mode, and an occupancy count tracks how many bytes are held. The block reports this count together with an empty flag and a full flag. Its ready output is the inverse of full, and the byte source uses it to stall.

A write to the control register empties the store in one cycle in two cases:

- the enable bit differs from the current mode, which also resizes the store; or
- the enable bit and the receive-clear bit are both set.

The byte at the head of the store is visible combinationally on the read data output. A read strobe removes that byte on the next clock edge.

Top module: `uart_rxbuf`

## Requirements
- R1: After reset the buffer is in legacy mode (`fifo_mode`=0), `fill_count` is 0, `empty` is 1, `full` is 0 and `in_ready` is 1.
- R2: In legacy mode the buffer holds one byte: one accepted push sets `full`, and a pop then returns that byte on `rd_data`.
- R3: A control write (`ctl_wr`=1) whose `ctl_fifo_en` differs from `fifo_mode` empties the buffer and sets `fifo_mode` to `ctl_fifo_en` on the next edge. A control write whose enable equals the mode and has `ctl_rx_clr`=0 changes nothing.
- R4: A control write with `ctl_fifo_en`=1 and `ctl_rx_clr`=1 empties the buffer and leaves it in FIFO mode. In legacy mode, `ctl_rx_clr` with `ctl_fifo_en`=0 has no effect.
- R5: In FIFO mode, up to `DEPTH` bytes are accepted and read back in arrival order. `full` rises when `fill_count` equals `DEPTH`.
- R6: A push while `full` is 1 is dropped. The count does not change and no stored byte is overwritten.
- R7: A pop while `empty` is 1 shows 0x00 on `rd_data` and leaves the count and the contents unchanged. A push in the same cycle is still accepted.
- R8: In the cycle in which a flush occurs, any push or pop is ignored, and `fill_count` is 0 afterwards.
- R9: A push and a pop in the same cycle on a buffer that is neither empty nor full keep `fill_count` constant. Order is preserved across index wrap-around.
- R10: `in_ready` equals the inverse of `full`. It returns to 1 on the edge after a pop frees an entry, and then a push is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Strobe for a write to the FIFO control register |
| ctl_fifo_en | input | 1 | Written enable bit: 1 selects FIFO mode, 0 selects legacy mode |
| ctl_rx_clr | input | 1 | Written receive-clear bit; takes effect only together with enable set |
| in_valid | input | 1 | Byte source offers `in_data` in this cycle |
| in_data | input | WIDTH | Received byte |
| in_ready | output | 1 | Buffer can accept a byte (not full) |
| rd_en | input | 1 | Pop strobe from the read path |
| rd_data | output | WIDTH | Byte at the head of the buffer, 0x00 when empty |
| fill_count | output | $clog2(DEPTH+1) | Number of stored bytes |
| empty | output | 1 | No bytes stored |
| full | output | 1 | Count equals the depth of the current mode |
| fifo_mode | output | 1 | Current mode: 1 is FIFO, 0 is legacy |

## Verification
A corrupted index or count shows at the ports within one pop:

- a stale or reordered byte appears on `rd_data`; or
- `fill_count` drifts away from the number of bytes pushed minus the number popped, one edge after the faulty update.

A missed flush or a wrong mode register shows up immediately after the control write. Either `fill_count` is not 0, or `full` rises at the wrong depth when the next push fills the buffer. A missing drop guard overwrites the oldest data, and the damage appears when that entry is popped.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

   typedef enum logic {
      MODE_LEGACY = 1'b0,
      MODE_FIFO   = 1'b1
   } rxbuf_mode_e;

endpackage

// File: rtl/rxbuf_mode_ctl.sv
module rxbuf_mode_ctl
   import rxbuf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctl_wr,
   input  logic        ctl_fifo_en,
   input  logic        ctl_rx_clr,
   output rxbuf_mode_e mode,
   output logic        flush
);

   rxbuf_mode_e mode_q;
   rxbuf_mode_e mode_req;
   logic        mode_change;
   logic        clr_cmd;

   assign mode_req    = ctl_fifo_en ? MODE_FIFO : MODE_LEGACY;
   assign mode_change = ctl_wr && (mode_req != mode_q);
   assign clr_cmd     = ctl_wr && ctl_fifo_en && ctl_rx_clr;
   assign flush       = mode_change || clr_cmd;
   assign mode        = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_LEGACY;
      end else if (ctl_wr) begin
         mode_q <= mode_req;
      end
   end

endmodule

// File: rtl/rxbuf_index_ctl.sv
module rxbuf_index_ctl
   import rxbuf_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  rxbuf_mode_e   mode,
   input  logic          flush,
   input  logic          push_req,
   input  logic          pop_req,
   output logic          wr_fire,
   output logic [AW-1:0] wr_idx,
   output logic [AW-1:0] rd_idx,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full
);

   logic [AW-1:0] wr_q, rd_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit;
   logic [CW-1:0] limit_m1;
   logic          rd_fire;

   assign limit    = (mode == MODE_FIFO) ? CW'(DEPTH) : CW'(1);
   assign limit_m1 = limit - CW'(1);

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == limit);
   assign wr_fire = push_req && !full && !flush;
   assign rd_fire = pop_req && !empty && !flush;

   function automatic logic [AW-1:0] step_idx(input logic [AW-1:0] idx,
                                              input logic [CW-1:0] last);
      if (CW'(idx) >= last) return '0;
      return idx + AW'(1);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (wr_fire) wr_q <= step_idx(wr_q, limit_m1);
         if (rd_fire) rd_q <= step_idx(rd_q, limit_m1);
         case ({wr_fire, rd_fire})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign wr_idx = wr_q;
   assign rd_idx = rd_q;
   assign count  = cnt_q;

endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
   parameter int WIDTH     = 8,
   parameter int DEPTH     = 16,
   parameter bit RESET_MEM = 1'b1,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      if (RESET_MEM) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem[i] <= '0;
            else if (we && (waddr == AW'(i))) mem[i] <= wdata;
         end
      end else begin : g_nrst
         always_ff @(posedge clk) begin
            if (we && (waddr == AW'(i))) mem[i] <= wdata;
         end
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/uart_rxbuf.sv
module uart_rxbuf
   import rxbuf_pkg::*;
#(
   parameter int WIDTH     = 8,
   parameter int DEPTH     = 16,
   parameter bit RESET_MEM = 1'b1,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic             ctl_fifo_en,
   input  logic             ctl_rx_clr,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] in_data,
   output logic             in_ready,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic [CW-1:0]    fill_count,
   output logic             empty,
   output logic             full,
   output logic             fifo_mode
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("uart_rxbuf: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("uart_rxbuf: WIDTH must be at least 1");
   end

   rxbuf_mode_e      mode;
   logic             flush;
   logic             wr_fire;
   logic [AW-1:0]    wr_idx, rd_idx;
   logic [WIDTH-1:0] head;
   logic             empty_i, full_i;

   rxbuf_mode_ctl u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_wr      (ctl_wr),
      .ctl_fifo_en (ctl_fifo_en),
      .ctl_rx_clr  (ctl_rx_clr),
      .mode        (mode),
      .flush       (flush)
   );

   rxbuf_index_ctl #(.DEPTH(DEPTH)) u_idx (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .flush    (flush),
      .push_req (in_valid),
      .pop_req  (rd_en),
      .wr_fire  (wr_fire),
      .wr_idx   (wr_idx),
      .rd_idx   (rd_idx),
      .count    (fill_count),
      .empty    (empty_i),
      .full     (full_i)
   );

   rxbuf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .RESET_MEM(RESET_MEM)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_fire),
      .waddr (wr_idx),
      .wdata (in_data),
      .raddr (rd_idx),
      .rdata (head)
   );

   assign empty     = empty_i;
   assign full      = full_i;
   assign in_ready  = !full_i;
   assign rd_data   = empty_i ? '0 : head;
   assign fifo_mode = (mode == MODE_FIFO);

endmodule

// File: rtl/rxbuf_chk.sv
module rxbuf_chk #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_wr,
   input logic             ctl_fifo_en,
   input logic             ctl_rx_clr,
   input logic             in_valid,
   input logic             in_ready,
   input logic             rd_en,
   input logic [WIDTH-1:0] rd_data,
   input logic [CW-1:0]    fill_count,
   input logic             empty,
   input logic             full,
   input logic             fifo_mode
);

   // R3
   mode_flip_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && (ctl_fifo_en != fifo_mode)) |=>
         (fill_count == '0) && (fifo_mode == $past(ctl_fifo_en)));

   // R4
   rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_fifo_en && ctl_rx_clr) |=> empty && fifo_mode);

   // R5
   depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_count <= (fifo_mode ? CW'(DEPTH) : CW'(1)));

   // R6
   no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && in_valid && !rd_en && !ctl_wr) |=> full && $stable(fill_count) && $stable(rd_data));

   // R7
   empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_en) |-> (rd_data == '0));

   // R7
   empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_en && !in_valid && !ctl_wr) |=> empty);

   // R9
   balanced_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && !full && in_valid && rd_en && !ctl_wr) |=> $stable(fill_count));

   // R10
   ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && rd_en && !in_valid && !ctl_wr) |=> in_ready);

endmodule

bind uart_rxbuf rxbuf_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_wr      (ctl_wr),
   .ctl_fifo_en (ctl_fifo_en),
   .ctl_rx_clr  (ctl_rx_clr),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .rd_en       (rd_en),
   .rd_data     (rd_data),
   .fill_count  (fill_count),
   .empty       (empty),
   .full        (full),
   .fifo_mode   (fifo_mode)
);

// File: tb/uart_rxbuf_tb.sv
`timescale 1ns/1ps
module uart_rxbuf_tb;

   localparam int DEPTH = 16;
   localparam int CW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_wr = 1'b0, ctl_fifo_en = 1'b0, ctl_rx_clr = 1'b0;
   logic          in_valid = 1'b0, rd_en = 1'b0;
   logic [7:0]    in_data = '0;
   logic          in_ready, empty, full, fifo_mode;
   logic [7:0]    rd_data;
   logic [CW-1:0] fill_count;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;

   logic [7:0] exp_q[$];
   bit         mdl_fifo = 1'b0;
   int         pre_cnt  = 0;
   bit         cur_flush = 1'b0;
   string      cur_tag = "";

   always #5 clk = ~clk;

   uart_rxbuf u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_fifo_en(ctl_fifo_en),
      .ctl_rx_clr(ctl_rx_clr), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .rd_en(rd_en), .rd_data(rd_data),
      .fill_count(fill_count), .empty(empty), .full(full), .fifo_mode(fifo_mode)
   );

   task automatic check(input string tag, input int act, input int exp, input string what);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int mdl_depth();
      return mdl_fifo ? DEPTH : 1;
   endfunction

   // Monitor: compares the head byte shown during a pop with the scoreboard.
   always @(negedge clk) begin
      #2;
      if (rst_n && rd_en && !cur_flush) begin
         if (pre_cnt == 0) begin
            check(cur_tag, int'(rd_data), 0, "rd_data on empty pop");
         end else begin
            check(cur_tag, int'(rd_data), int'(exp_q[0]), "rd_data order");
            void'(exp_q.pop_front());
         end
      end
   end

   // Driver: one cycle of stimulus; updates the model and checks the state.
   task automatic step(input string tag, input bit p, input logic [7:0] d,
                       input bit r, input bit w = 1'b0, input bit e = 1'b0,
                       input bit c = 1'b0);
      @(negedge clk);
      #1;
      in_valid = p; in_data = d; rd_en = r;
      ctl_wr = w; ctl_fifo_en = e; ctl_rx_clr = c;
      cur_tag   = tag;
      pre_cnt   = exp_q.size();
      cur_flush = w && ((e != mdl_fifo) || (e && c));
      if (cur_flush) begin
         exp_q.delete();
         mdl_fifo = e;
      end else if (w) begin
         mdl_fifo = e;
      end else if (p && pre_cnt < mdl_depth()) begin
         exp_q.push_back(d);
      end
      if (!cur_flush && p && w && pre_cnt < mdl_depth()) exp_q.push_back(d);
      @(posedge clk);
      #1;
      in_valid = 0; rd_en = 0; ctl_wr = 0; ctl_rx_clr = 0;
      check(tag, int'(fill_count), exp_q.size(), "fill_count");
      check(tag, int'(full), int'(exp_q.size() == mdl_depth()), "full");
      check(tag, int'(empty), int'(exp_q.size() == 0), "empty");
      check(tag, int'(in_ready), int'(exp_q.size() != mdl_depth()), "in_ready");
      check(tag, int'(fifo_mode), int'(mdl_fifo), "fifo_mode");
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1", int'(fill_count), 0, "fill_count");
      check("R1", int'(empty), 1, "empty");
      check("R1", int'(full), 0, "full");
      check("R1", int'(in_ready), 1, "in_ready");
      check("R1", int'(fifo_mode), 0, "fifo_mode");
      rst_n = 1'b1;

      // R2: single-byte legacy holding register
      step("R2", 1, 8'hA5, 0);
      step("R6", 1, 8'h3C, 0);         // dropped, A5 kept
      step("R2", 0, 8'h00, 1);         // reads A5
      step("R7", 0, 8'h00, 1);         // empty pop returns 0
      step("R7", 1, 8'h5A, 1);         // empty pop ignored, push accepted
      step("R2", 0, 8'h00, 1);

      // R4: receive-clear without enable in legacy mode does nothing
      step("R4", 1, 8'h11, 0);
      step("R4", 0, 8'h00, 0, 1, 0, 1);
      step("R2", 0, 8'h00, 1);

      // R3: enabling flushes and resizes
      step("R3", 1, 8'h22, 0);
      step("R3", 0, 8'h00, 0, 1, 1, 0);

      // R5: fill to full depth in FIFO mode
      for (int i = 0; i < DEPTH; i++) step("R5", 1, 8'(8'h40 + i), 0);
      step("R6", 1, 8'hEE, 0);         // dropped when full
      step("R6", 1, 8'hEF, 1);         // full: pop only
      step("R10", 1, 8'h77, 0);        // ready again, accepted
      for (int i = 0; i < 5; i++) step("R5", 0, 8'h00, 1);
      // R9: balanced traffic across the wrap point
      for (int i = 0; i < 12; i++) step("R9", 1, 8'(8'h80 + i), 1);
      // R3: same-enable write without clear changes nothing
      step("R3", 0, 8'h00, 0, 1, 1, 0);
      for (int i = 0; i < 4; i++) step("R5", 0, 8'h00, 1);

      // R8: flush via receive-clear with push and pop in the same cycle
      step("R8", 1, 8'h99, 1, 1, 1, 1);
      step("R4", 1, 8'h31, 0);
      step("R4", 1, 8'h32, 0);
      step("R4", 0, 8'h00, 0, 1, 1, 1);

      // R3: disabling flushes and returns to one entry
      step("R3", 1, 8'h61, 0);
      step("R3", 0, 8'h00, 0, 1, 0, 0);
      step("R2", 1, 8'h62, 0);
      step("R6", 1, 8'h63, 0);
      step("R2", 0, 8'h00, 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule